// File: doc/BRIEF.md
# Gated Edge-Count Frequency Meter

The block measures the frequency of an external, asynchronous pulse signal. The signal is brought into the system clock domain, and its rising edges are counted inside a gate window of known length. An internal timer makes a square gate. The gate is high for one gate time and then low for one gate time. While the gate is high, a down-counter that was preset to its full-scale value steps down once for each detected edge. In the first gate-low cycle the block reads the counter. It computes the number of edges as full scale minus the residue, scales that number to hertz, and then presets the counter again for the next window.

There are two gate times. The long gate is one second, which is `CLK_HZ` clock cycles and gives 1 Hz resolution. The short gate is a tenth of that and gives 10 Hz resolution. Each short-gate count is multiplied by `FINE_DIV` (10), so no divider is needed. A fast-repeat control restarts the timer as soon as a readout happens, which shortens the gate-low time to a single cycle.

Results leave the block on a valid/ready interface. The rules for back-pressure are these:
- The producer never waits for the consumer.
- A held result stays valid until `res_ready` is seen high at a clock edge.
- If a new readout happens while an older result is still held, the new result replaces it.

Top module: `freq_meter`

## Requirements
- R1: The gate is high for G cycles and then low, where G = `CLK_HZ` when `gate_fine`=0 and G = `CLK_HZ/FINE_DIV` when `gate_fine`=1. With `fast_repeat`=0, readouts follow each other every 2G cycles.
- R2: `fin_async` passes through a two-flop synchronizer and a rising-edge detector. Each input rise (high and low each held for at least two clocks) steps the counter once, but only if the detected edge pulse falls in a gate-high cycle. Edges detected while the gate is low change nothing.
- R3: The `CNT_W`-bit counter starts at full scale (all ones) and steps down. An edge that arrives at zero keeps the counter at zero and sets an overflow flag. The result of that window is full scale times the scale factor, with `res_ovf`=1.
- R4: The readout happens in the first gate-low cycle. It gives `res_hz` = (full scale − residue) × `FINE_DIV` for the short gate, or × 1 for the long gate. It also presets the counter to full scale and clears the overflow flag.
- R5: `gate_fine` is sampled only at the start of each window. A change in the middle of a window takes effect from the next window.
- R6: With `fast_repeat`=1, the timer restarts on the readout edge. The gate is then low for one cycle, and readouts follow each other every G+1 cycles.
- R7: `res_valid` rises one cycle after the readout. It stays high, with the result held, while `res_ready` is 0. A newer readout overwrites the held result. With `res_ready` held at 1, `res_valid` lasts one cycle.
- R8: Under reset, `res_valid`, `res_hz` and `res_ovf` are 0. The first window opens on the first clock after reset is released, so the first `res_valid` is seen G+2 clock edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fin_async | input | 1 | Pulse signal to be measured, asynchronous |
| gate_fine | input | 1 | 1 selects the short gate (10 Hz steps), 0 the long gate (1 Hz steps) |
| fast_repeat | input | 1 | 1 restarts the gate timer at readout |
| res_hz | output | RES_W | Measured frequency in hertz |
| res_ovf | output | 1 | The counter saturated during the window |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |

## Verification
The bench uses the following input patterns. Each one tells apart a different way the counting or the timing could go wrong.
- **Random-rate toggling below full scale** shows whether every edge inside the gate is counted and whether the residue is subtracted and scaled correctly for both gates.
- **Maximum-rate toggling** drives the counter past zero, which separates saturation with the overflow flag from wrap-around.
- **A silent input** must give an exact zero.
- **Changing the gate select in the middle of a window, and switching fast repeat on**, are seen in the spacing between readouts (2G, G+1, and the one-window delay before the new gate length applies).
- **A stall on `res_ready` that spans two readouts** separates "latest result wins" from "first result kept" and from a valid signal that drops on its own.

// File: rtl/fm_pkg.sv
package fm_pkg;

  typedef enum logic {
    GATE_LONG  = 1'b0,
    GATE_SHORT = 1'b1
  } gate_len_e;

endpackage

// File: rtl/fm_sync_edge.sv
module fm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  // Chain of STAGES synchronizer flops plus one flop that keeps the previous value.
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], din};
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/fm_gate_timer.sv
module fm_gate_timer import fm_pkg::*; #(
  parameter int LONG_CYC  = 1000,
  parameter int SHORT_CYC = 100
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      short_sel,
  input  logic      fast_repeat,
  output logic      gate,
  output logic      rd,
  output gate_len_e sel_q
);

  localparam int TW = $clog2(2 * LONG_CYC);
  localparam logic [TW-1:0] HALF_L = TW'(LONG_CYC);
  localparam logic [TW-1:0] HALF_S = TW'(SHORT_CYC);
  localparam logic [TW-1:0] LAST_L = TW'(2 * LONG_CYC - 1);
  localparam logic [TW-1:0] LAST_S = TW'(2 * SHORT_CYC - 1);

  logic          run_q;
  logic [TW-1:0] tcnt_q;
  logic [TW-1:0] half;
  logic [TW-1:0] last;
  logic          restart;

  assign half    = (sel_q == GATE_SHORT) ? HALF_S : HALF_L;
  assign last    = (sel_q == GATE_SHORT) ? LAST_S : LAST_L;
  assign gate    = run_q && (tcnt_q < half);
  assign rd      = run_q && (tcnt_q == half);
  assign restart = (tcnt_q == last) || (rd && fast_repeat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      tcnt_q <= '0;
      sel_q  <= GATE_LONG;
    end else if (!run_q) begin
      // First window after reset: take the gate select and start.
      run_q  <= 1'b1;
      tcnt_q <= '0;
      sel_q  <= gate_len_e'(short_sel);
    end else if (restart) begin
      tcnt_q <= '0;
      sel_q  <= gate_len_e'(short_sel);
    end else begin
      tcnt_q <= tcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/fm_down_counter.sv
module fm_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] FULL = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= FULL;
      ovf <= 1'b0;
    end else if (load) begin
      cnt <= FULL;
      ovf <= 1'b0;
    end else if (step) begin
      // At zero the counter holds its value and flags the overflow.
      if (cnt == '0) ovf <= 1'b1;
      else           cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/fm_result_stage.sv
module fm_result_stage import fm_pkg::*; #(
  parameter int CNT_W    = 16,
  parameter int RES_W    = 20,
  parameter int FINE_DIV = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [CNT_W-1:0] residue,
  input  logic             ovf_in,
  input  gate_len_e        sel,
  output logic [RES_W-1:0] res,
  output logic             res_ovf,
  output logic             valid,
  input  logic             ready
);

  localparam logic [CNT_W-1:0] FULL = '1;

  logic [CNT_W-1:0] edges;
  logic [RES_W-1:0] edges_w;
  logic [RES_W-1:0] scaled;

  assign edges   = FULL - residue;
  assign edges_w = RES_W'(edges);

  generate
    if (FINE_DIV == 1) begin : g_unit
      assign scaled = edges_w;
    end else begin : g_mul
      assign scaled = (sel == GATE_SHORT) ? edges_w * RES_W'(FINE_DIV) : edges_w;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res     <= '0;
      res_ovf <= 1'b0;
      valid   <= 1'b0;
    end else if (capture) begin
      // The newest readout always replaces whatever is held.
      res     <= scaled;
      res_ovf <= ovf_in;
      valid   <= 1'b1;
    end else if (ready) begin
      valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/freq_meter.sv
module freq_meter import fm_pkg::*; #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int FINE_DIV    = 10,
  parameter int CNT_W       = 16,
  parameter int RES_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin_async,
  input  logic             gate_fine,
  input  logic             fast_repeat,
  output logic [RES_W-1:0] res_hz,
  output logic             res_ovf,
  output logic             res_valid,
  input  logic             res_ready
);

  localparam int LONG_CYC  = CLK_HZ;
  localparam int SHORT_CYC = CLK_HZ / FINE_DIV;

  logic             edge_pulse;
  logic             gate;
  logic             rd_pulse;
  gate_len_e        sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_ovf;
  logic             step;

  fm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (fin_async),
    .rise (edge_pulse)
  );

  fm_gate_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .short_sel  (gate_fine),
    .fast_repeat(fast_repeat),
    .gate       (gate),
    .rd         (rd_pulse),
    .sel_q      (sel_q)
  );

  assign step = edge_pulse & gate;

  fm_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .load (rd_pulse),
    .step (step),
    .cnt  (cnt_q),
    .ovf  (cnt_ovf)
  );

  fm_result_stage #(.CNT_W(CNT_W), .RES_W(RES_W), .FINE_DIV(FINE_DIV)) u_res (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(rd_pulse),
    .residue(cnt_q),
    .ovf_in (cnt_ovf),
    .sel    (sel_q),
    .res    (res_hz),
    .res_ovf(res_ovf),
    .valid  (res_valid),
    .ready  (res_ready)
  );

endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate,
  input logic             rd,
  input logic [CNT_W-1:0] cnt,
  input logic             ovf,
  input logic             res_valid,
  input logic             res_ready
);

  localparam logic [CNT_W-1:0] FULL = '1;

  assert_read_gate_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> !gate);

  assert_reload_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> (cnt == FULL));

  assert_frozen_when_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !rd) |=> $stable(cnt));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !rd) |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) - CNT_W'(1))));

  assert_overflow_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> (cnt == '0));

  assert_valid_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid);

endmodule

bind freq_meter fm_checker #(.CNT_W(CNT_W)) u_fm_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gate     (gate),
  .rd       (rd_pulse),
  .cnt      (cnt_q),
  .ovf      (cnt_ovf),
  .res_valid(res_valid),
  .res_ready(res_ready)
);

// File: tb/freq_meter_bench.sv
`timescale 1ns/1ps
module freq_meter_bench;

  localparam int CLK_HZ = 4000;
  localparam int MUL    = 10;
  localparam int CW     = 8;
  localparam int RW     = 20;
  localparam int SG     = CLK_HZ;
  localparam int FG     = CLK_HZ / MUL;
  localparam int FS     = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fin_async = 1'b0;
  logic          gate_fine = 1'b0;
  logic          fast_repeat = 1'b0;
  logic          res_ready = 1'b1;
  logic [RW-1:0] res_hz;
  logic          res_ovf;
  logic          res_valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int seen   = 0;
  int last_stamp = 0;
  int prev_stamp = 0;

  // Stimulus control for the input generator.
  int fin_on = 0;
  int fin_lo = 2;
  int fin_hi = 2;

  // Reference model state.
  bit m1, m2, m3, mrun, msel, movf;
  int mt, mcnt, exp_res, exp_ovf;

  always #5 clk = ~clk;

  freq_meter #(.CLK_HZ(CLK_HZ), .FINE_DIV(MUL), .CNT_W(CW), .RES_W(RW)) u_freq_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .fin_async  (fin_async),
    .gate_fine  (gate_fine),
    .fast_repeat(fast_repeat),
    .res_hz     (res_hz),
    .res_ovf    (res_ovf),
    .res_valid  (res_valid),
    .res_ready  (res_ready)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int scale_of(input bit fine, input int edges);
    return fine ? edges * MUL : edges;
  endfunction

  always @(posedge clk) cyc++;

  // Cycle model built from the requirements (R1, R2, R3, R4, R5, R6, R8).
  always @(posedge clk) begin
    if (!rst_n) begin
      m1 = 0; m2 = 0; m3 = 0; mrun = 0; msel = 0; movf = 0;
      mt = 0; mcnt = FS; exp_res = 0; exp_ovf = 0;
    end else begin
      int g;
      bit edge_d, gate_m, rd_m;
      g      = msel ? FG : SG;
      edge_d = m2 && !m3;
      gate_m = mrun && (mt < g);
      rd_m   = mrun && (mt == g);
      if (rd_m) begin
        exp_res = scale_of(msel, FS - mcnt);
        exp_ovf = movf;
        mcnt = FS;
        movf = 0;
      end else if (gate_m && edge_d) begin
        if (mcnt == 0) movf = 1;
        else mcnt = mcnt - 1;
      end
      if (!mrun) begin
        mrun = 1; mt = 0; msel = gate_fine;
      end else if ((mt == 2 * g - 1) || (rd_m && fast_repeat)) begin
        mt = 0; msel = gate_fine;
      end else begin
        mt = mt + 1;
      end
      m3 = m2; m2 = m1; m1 = fin_async;
    end
  end

  // Result monitor: compares every accepted result with the model.
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      chk(res_hz == RW'(exp_res), "R4", res_hz, exp_res);
      chk(res_ovf == exp_ovf[0], "R3", res_ovf, exp_ovf);
      prev_stamp = last_stamp;
      last_stamp = cyc;
      seen++;
    end
  end

  // Input generator driven on falling edges.
  initial begin
    forever begin
      if (fin_on == 0) begin
        fin_async = 1'b0;
        @(negedge clk);
      end else begin
        int h;
        h = $urandom_range(fin_hi, fin_lo);
        fin_async = 1'b1;
        repeat (h) @(negedge clk);
        h = $urandom_range(fin_hi, fin_lo);
        fin_async = 1'b0;
        repeat (h) @(negedge clk);
      end
    end
  end

  task automatic wait_res(input int n);
    int tgt;
    tgt = seen + n;
    while (seen < tgt) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1: watchdog expired, actual %0d results expected more", seen);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int c0;
    void'($urandom(32'd7319));

    // R8: reset state
    repeat (4) @(negedge clk);
    chk(res_valid == 1'b0, "R8", res_valid, 0);
    chk(res_hz == '0, "R8", res_hz, 0);
    chk(res_ovf == 1'b0, "R8", res_ovf, 0);

    // Long gate, random slow input.
    fin_on = 1; fin_lo = 10; fin_hi = 40;
    c0 = cyc;
    rst_n = 1'b1;
    wait_res(1);
    chk(last_stamp == c0 + SG + 2, "R8", last_stamp, c0 + SG + 2);
    wait_res(2);
    chk(last_stamp - prev_stamp == 2 * SG, "R1", last_stamp - prev_stamp, 2 * SG);

    // R3: maximum rate on the long gate saturates the counter.
    fin_lo = 2; fin_hi = 2;
    wait_res(2);
    chk(res_ovf == 1'b1, "R3", res_ovf, 1);
    chk(res_hz == RW'(FS), "R3", res_hz, FS);

    // R4: silent input on the short gate gives zero.
    fin_on = 0;
    gate_fine = 1'b1;
    wait_res(3);
    chk(res_hz == '0 && res_ovf == 1'b0, "R4", res_hz, 0);

    // Short gate, random input.
    fin_on = 1; fin_lo = 2; fin_hi = 5;
    wait_res(4);
    chk(last_stamp - prev_stamp == 2 * FG, "R1", last_stamp - prev_stamp, 2 * FG);

    // R6: fast repeat.
    fast_repeat = 1'b1;
    wait_res(4);
    chk(last_stamp - prev_stamp == FG + 1, "R6", last_stamp - prev_stamp, FG + 1);
    @(negedge clk);
    chk(res_valid == 1'b0, "R7", res_valid, 0);

    // R5: the select changes in the middle of a window.
    fin_lo = 10; fin_hi = 30;
    wait_res(1);
    gate_fine = 1'b0;
    wait_res(1);
    chk(last_stamp - prev_stamp == FG + 1, "R5", last_stamp - prev_stamp, FG + 1);
    wait_res(1);
    chk(last_stamp - prev_stamp == SG + 1, "R5", last_stamp - prev_stamp, SG + 1);

    // R7: back-pressure across two readouts, the latest result is kept.
    gate_fine = 1'b1;
    fin_lo = 2; fin_hi = 6;
    wait_res(2);
    @(negedge clk);
    res_ready = 1'b0;
    repeat (900) @(negedge clk);
    chk(res_valid == 1'b1, "R7", res_valid, 1);
    chk(res_hz == RW'(exp_res), "R7", res_hz, exp_res);
    res_ready = 1'b1;
    wait_res(1);
    wait_res(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule